// File: doc/BRIEF.md
# Two-Channel Offset Calibration Sequencer

This block removes DC offset from a two-channel stream of 24-bit signed samples. Once the synchronous reset goes away, it runs one calibration pass without being told to. During that pass it sums a fixed number of valid samples on each channel and keeps the average of each sum as that channel's correction. A busy flag stays high for the whole pass. While the pass runs, the block still emits one output per input sample, but each output is zero.

After calibration, each incoming sample has its channel's stored correction subtracted. The result saturates instead of wrapping. An optional first-order DC blocker can follow the subtraction, to track drift continuously. A registered copy of the reference-select input goes out to steer the external analog multiplexer. A low value picks the common-mode reference and a high value picks the live inputs.

Top module: `ocal_seq_top`

## Requirements
- R1: While `rst` is high, `cal_busy_o`, `out_valid_o` and `mux_sel_o` read 0 one cycle later, and input samples are ignored.
- R2: On the first clock edge with `rst` low, the block enters calibration, and `cal_busy_o` is 1 from the next cycle. A sample presented in that first cycle is neither counted nor echoed.
- R3: `cal_busy_o` stays 1 for exactly N = 2^CAL_LOG2 valid samples and falls on the edge that takes the Nth sample. Cycles without `smp_valid_i` do not count.
- R4: During calibration, every valid input produces `out_valid_o` = 1 one cycle later, with both outputs equal to 0. This includes the Nth sample.
- R5: The correction for each channel is floor(sum of its N calibration samples / N), which is an arithmetic right shift.
- R6: After calibration, each valid sample produces an output one cycle later equal to the input minus that channel's correction.
- R7: The subtraction, and the DC blocker, saturate at +8388607 and -8388608 (24-bit two's complement) instead of wrapping.
- R8: `mux_sel_o` equals `ref_sel_i` delayed by one cycle. A value of 0 selects the common-mode reference and 1 selects the live inputs.
- R9: With `hpf_en_i` = 1, the output is y = c - cp + yp - floor(yp/4096), saturated. Here c is the corrected sample, and cp and yp are the previous corrected sample and previous output; both start at 0 and update on each valid run sample. With `hpf_en_i` = 0, the output is c, and cp and yp are cleared to 0.
- R10: `out_valid_o` is 1 only in the cycle after a valid input. Invalid cycles change no output and advance no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sel_i | input | 1 | Calibration source: 0 common-mode, 1 live inputs |
| hpf_en_i | input | 1 | DC blocker enable |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_l_i | input | DW | Left input sample, signed |
| smp_r_i | input | DW | Right input sample, signed |
| mux_sel_o | output | 1 | Registered multiplexer control |
| cal_busy_o | output | 1 | Calibration in progress |
| out_valid_o | output | 1 | Output sample strobe |
| out_l_o | output | DW | Left corrected sample |
| out_r_o | output | DW | Right corrected sample |

## Verification
A sample counter that is off by one shows up quickly. The busy flag falls one sample early or late, and every output after that point is shifted by the wrong correction, so the first corrected sample already disagrees with the bench's arithmetic. A wrong accumulator width or a wrong shift direction changes the correction by a whole number of LSBs, which is visible on every run-phase sample. A stale or uncleared DC blocker state shows up on the first sample after the filter is switched on or off. Saturation faults only appear at the extreme inputs, so the bench drives the full-scale values against large corrections of both signs.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_RUN  = 2'd2
  } ocal_state_e;
endpackage

// File: rtl/ocal_sat.sv
module ocal_sat #(
  parameter int IW = 26,
  parameter int OW = 24
) (
  input  logic signed [IW-1:0] in_i,
  output logic signed [OW-1:0] out_o
);
  localparam logic signed [IW-1:0] HI = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW-1:0] LO = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  always_comb begin
    if (in_i > HI)      out_o = HI[OW-1:0];
    else if (in_i < LO) out_o = LO[OW-1:0];
    else                out_o = in_i[OW-1:0];
  end
endmodule

// File: rtl/ocal_accum.sv
module ocal_accum #(
  parameter int DW       = 24,
  parameter int CAL_LOG2 = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_i,
  input  logic                 add_i,
  input  logic                 last_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] off_o
);
  localparam int AW = DW + CAL_LOG2;

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] sum;
  logic signed [AW-1:0] avg;

  assign sum = acc_q + {{CAL_LOG2{x_i[DW-1]}}, x_i};
  assign avg = sum >>> CAL_LOG2;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      off_o <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
    end else if (add_i) begin
      if (last_i) begin
        off_o <= avg[DW-1:0];
        acc_q <= '0;
      end else begin
        acc_q <= sum;
      end
    end
  end
endmodule

// File: rtl/ocal_dcblock.sv
module ocal_dcblock #(
  parameter int DW        = 24,
  parameter int HPF_SHIFT = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic                 step_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] y_o
);
  localparam int FW = DW + 3;

  logic signed [DW-1:0] xp_q, yp_q;
  logic signed [DW-1:0] y_sat;
  logic signed [FW-1:0] fsum;

  assign fsum = FW'(x_i) - FW'(xp_q) + FW'(yp_q) - FW'(yp_q >>> HPF_SHIFT);

  ocal_sat #(.IW(FW), .OW(DW)) sat_i (.in_i(fsum), .out_o(y_sat));

  assign y_o = en_i ? y_sat : x_i;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      xp_q <= '0;
      yp_q <= '0;
    end else if (step_i) begin
      xp_q <= x_i;
      yp_q <= y_sat;
    end
  end

  // R10: filter history only moves on a taken sample
  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (en_i && !step_i) |=> (!en_i || ($stable(xp_q) && $stable(yp_q))));
endmodule

// File: rtl/ocal_seq_top.sv
module ocal_seq_top
  import ocal_pkg::*;
#(
  parameter int DW        = 24,
  parameter int CAL_LOG2  = 10,
  parameter int HPF_SHIFT = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_sel_i,
  input  logic                 hpf_en_i,
  input  logic                 smp_valid_i,
  input  logic signed [DW-1:0] smp_l_i,
  input  logic signed [DW-1:0] smp_r_i,
  output logic                 mux_sel_o,
  output logic                 cal_busy_o,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] out_l_o,
  output logic signed [DW-1:0] out_r_o
);
  localparam int NCH = 2;
  localparam logic [CAL_LOG2-1:0] LAST_IDX = '1;

  ocal_state_e          state_q;
  logic [CAL_LOG2-1:0]  cnt_q;
  logic                 take, last;
  logic signed [DW-1:0] x_ch  [NCH];
  logic signed [DW-1:0] y_ch  [NCH];
  logic signed [DW-1:0] out_q [NCH];

  assign x_ch[0] = smp_l_i;
  assign x_ch[1] = smp_r_i;
  assign take    = smp_valid_i && (state_q == ST_CAL);
  assign last    = take && (cnt_q == LAST_IDX);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic signed [DW-1:0] off;
    logic signed [DW:0]   diff;
    logic signed [DW-1:0] corr;

    ocal_accum #(.DW(DW), .CAL_LOG2(CAL_LOG2)) acc_i (
      .clk(clk), .rst(rst), .clr_i(state_q == ST_IDLE),
      .add_i(take), .last_i(last), .x_i(x_ch[ch]), .off_o(off));

    assign diff = (DW+1)'(x_ch[ch]) - (DW+1)'(off);

    ocal_sat #(.IW(DW+1), .OW(DW)) sub_sat_i (.in_i(diff), .out_o(corr));

    ocal_dcblock #(.DW(DW), .HPF_SHIFT(HPF_SHIFT)) dcb_i (
      .clk(clk), .rst(rst), .en_i(hpf_en_i),
      .step_i(smp_valid_i && state_q == ST_RUN),
      .x_i(corr), .y_o(y_ch[ch]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      mux_sel_o   <= 1'b0;
      out_valid_o <= 1'b0;
      for (int ch = 0; ch < NCH; ch++) out_q[ch] <= '0;
    end else begin
      mux_sel_o   <= ref_sel_i;
      out_valid_o <= smp_valid_i && (state_q != ST_IDLE);
      case (state_q)
        ST_IDLE: state_q <= ST_CAL;
        ST_CAL: if (take) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
      if (smp_valid_i && state_q != ST_IDLE)
        for (int ch = 0; ch < NCH; ch++)
          out_q[ch] <= (state_q == ST_RUN) ? y_ch[ch] : '0;
    end
  end

  assign cal_busy_o = (state_q == ST_CAL);
  assign out_l_o    = out_q[0];
  assign out_r_o    = out_q[1];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!cal_busy_o && !out_valid_o));

  assert_auto_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> cal_busy_o);

  assert_busy_end_on_sample_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_busy_o) |-> $past(smp_valid_i));

  assert_cal_zero_out_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(cal_busy_o) && out_valid_o) |-> (out_l_o == '0 && out_r_o == '0));

  assert_valid_follows_input_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> $past(smp_valid_i));
endmodule

// File: tb/ocal_seq_top_tb_top.sv
`timescale 1ns/1ps
module ocal_seq_top_tb_top;
  localparam int DW = 24;
  localparam int CL = 4;
  localparam int N  = 1 << CL;
  localparam longint MAXV = 8388607;
  localparam longint MINV = -8388608;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_sel = 1'b0, hpf_en = 1'b0, vld = 1'b0;
  logic signed [DW-1:0] in_l = '0, in_r = '0;
  logic mux_sel, busy, ovld;
  logic signed [DW-1:0] o_l, o_r;

  int checks = 0, fails = 0;
  longint off_l, off_r, cp_l, cp_r, yp_l, yp_r;

  always #4 clk = ~clk;

  ocal_seq_top #(.DW(DW), .CAL_LOG2(CL), .HPF_SHIFT(12)) dut_i (
    .clk(clk), .rst(rst), .ref_sel_i(ref_sel), .hpf_en_i(hpf_en),
    .smp_valid_i(vld), .smp_l_i(in_l), .smp_r_i(in_r),
    .mux_sel_o(mux_sel), .cal_busy_o(busy), .out_valid_o(ovld),
    .out_l_o(o_l), .out_r_o(o_r));

  function automatic longint sat(longint v);
    return (v > MAXV) ? MAXV : (v < MINV) ? MINV : v;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic v, longint l, longint r);
    @(negedge clk);
    vld = v; in_l = DW'(l); in_r = DW'(r);
    @(posedge clk); #1;
  endtask

  task automatic calibrate(bit use_const, longint cl, longint cr);
    longint sl = 0, sr = 0;
    @(negedge clk); rst = 1'b1; vld = 1'b1; in_l = 24'sd77; in_r = -24'sd5;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 busy", busy, 0); chk("R1 valid", ovld, 0); chk("R1 mux", mux_sel, 0);
    @(negedge clk); rst = 1'b0; vld = 1'b0; ref_sel = use_const ? 1'b0 : 1'b1;
    @(posedge clk); #1;
    chk("R2 busy rises", busy, 1);
    chk("R8 mux", mux_sel, use_const ? 0 : 1);
    for (int i = 0; i < N; i++) begin
      longint l = use_const ? cl : 1000 + 37*i - (i % 3) * 500;
      longint r = use_const ? cr : -7 - 13*i;
      if (i == 5) begin
        cyc(1'b0, 12345, 999);
        chk("R10 no valid", ovld, 0); chk("R3 busy gap", busy, 1);
      end
      sl += l; sr += r;
      cyc(1'b1, l, r);
      chk("R4 valid", ovld, 1); chk("R4 zero l", o_l, 0); chk("R4 zero r", o_r, 0);
      chk("R3 busy", busy, (i < N-1) ? 1 : 0);
    end
    off_l = sl >>> CL; off_r = sr >>> CL;
    cp_l = 0; cp_r = 0; yp_l = 0; yp_r = 0;
  endtask

  task automatic run(longint l, longint r, string req);
    longint cl = sat(l - off_l), cr = sat(r - off_r);
    longint el, er;
    if (hpf_en) begin
      el = sat(cl - cp_l + yp_l - (yp_l >>> 12));
      er = sat(cr - cp_r + yp_r - (yp_r >>> 12));
      cp_l = cl; cp_r = cr; yp_l = el; yp_r = er;
    end else begin
      el = cl; er = cr; cp_l = 0; cp_r = 0; yp_l = 0; yp_r = 0;
    end
    cyc(1'b1, l, r);
    chk({req, " valid"}, ovld, 1);
    chk({req, " l"}, o_l, el);
    chk({req, " r"}, o_r, er);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    calibrate(1'b0, 0, 0);
    chk("R5 off_l sign", off_l > 0, 1);
    chk("R5 off_r sign", off_r < 0, 1);
    for (int k = 0; k < 200; k++) begin
      longint l = ((longint'(k) * 104729) % 16777216) - 8388608;
      longint r = ((longint'(k) * 7919 + 3) % 16777216) - 8388608;
      run(l, r, "R6/R5 sweep");
      if (k % 50 == 7) begin
        cyc(1'b0, 1, 1);
        chk("R10 hold valid", ovld, 0);
      end
    end
    run(MINV, MAXV, "R7 sat");
    run(MAXV, MINV, "R7 edge");
    ref_sel = 1'b0; @(posedge clk); #1; chk("R8 mux low", mux_sel, 0);
    hpf_en = 1'b1;
    for (int k = 0; k < 300; k++)
      run(400000 + (k % 7) * 1000 - (k % 2) * 50000, -300000 + k * 11, "R9 hpf");
    run(MAXV, MINV, "R9 hpf sat");
    run(MINV, MAXV, "R9 hpf sat2");
    hpf_en = 1'b0;
    for (int k = 0; k < 10; k++) run(k * 1000, -k * 999, "R9 bypass");
    hpf_en = 1'b1;
    for (int k = 0; k < 20; k++) run(5000 + k, -5000, "R9 restart");
    hpf_en = 1'b0;
    calibrate(1'b1, -8000000, 8000000);
    chk("R5 const l", off_l, -8000000); chk("R5 const r", off_r, 8000000);
    run(1000000, -1000000, "R7 sat both");
    run(-300, 300, "R6 small");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule